// File: doc/BRIEF.md
# Receive Timeout Interrupt Unit

This block raises the receive-timeout interrupt for a serial receiver that sits in front of a receive FIFO. A down-counter advances on a character-time tick. It is compared against a 16-bit limit that software writes one byte at a time. When the counter runs out, a sticky timeout flag is set. Software clears the flag by reading the interrupt identification register. The block reports that register through a priority encoder, and a line-status error always takes precedence over the timeout.

Two counting modes are available, selected by one control bit.

- **Data-pending mode:** the counter runs only while the FIFO holds data. Every received character and every FIFO read restarts the period. A timeout therefore means that characters are sitting unread and no traffic has arrived for a full period.
- **Periodic mode:** the counter runs freely and reloads itself on every expiry, whatever the FIFO state. This suits a consumer that drains the FIFO on a fixed cadence.

Software may change modes at any time, and the change applies from the next counter evaluation. The register bus uses single-cycle access. Read data is combinational in the access cycle, and writes take effect at the clock edge.

Top module: `rto_unit`

## Requirements
- R1: After synchronous reset, `irq_o` is 0 and `iid_o` is 4'b0001. The limit bytes and the control byte all read 0, so the timeout is disabled.
- R2: The limit is {byte at address 2, byte at address 1}. Each byte is written with a bus write and reads back unchanged.
- R3: In data-pending mode (control bit 6 = 0), a received character, a FIFO read, or an empty FIFO reloads the counter to the limit. With data pending and neither strobe present, the timeout flag sets at the edge of the limit-th tick. It is visible from the following cycle.
- R4: In data-pending mode, if data is still pending after the flag is cleared, the flag sets again after another full period of ticks.
- R5: In periodic mode (control bit 6 = 1), the flag sets on every limit-th tick and the counter reloads itself. The receive strobe, the FIFO read strobe and the empty flag have no effect on the count.
- R6: A write to the control byte at address 6 switches the mode at run time, with no reset. The new mode governs the counter from the next cycle.
- R7: A read of address 3 clears the timeout flag when the timeout is the reported source. If an expiry happens in the same cycle, the flag stays set.
- R8: Reads of address 0 (receive data, returns 0), address 4 (line status, returns {7'b0, line_err_i}) and address 5 (modem status, returns 0) leave the timeout flag unchanged. So do bus writes.
- R9: `iid_o` is 4'b0110 while `line_err_i` is high, otherwise 4'b1100 while the timeout flag is set, otherwise 4'b0001. `irq_o` is high whenever `iid_o` is not 4'b0001. A read of address 3 returns {4'b0, iid_o}. While `line_err_i` is high, that read does not clear the timeout flag.
- R10: While the limit is 0, the counter holds at 0 and the timeout flag never sets, in either mode.
- R11: The counter reloads with no tick when the limit is non-zero and the counter is at 0. This happens after a limit is first programmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle character-time tick |
| rx_push_i | input | 1 | A character was written into the receive FIFO |
| rx_pop_i | input | 1 | A character was read out of the receive FIFO |
| fifo_empty_i | input | 1 | Receive FIFO holds no data |
| line_err_i | input | 1 | Line-status error interrupt source is active |
| bus_sel_i | input | 1 | Register access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational in the access cycle |
| irq_o | output | 1 | Interrupt request |
| iid_o | output | 4 | Interrupt identification code |

## Verification
Read data is due in the access cycle itself, so the bench samples it shortly after driving the read, before the clock edge. The flag is updated at the edge where the limit-th tick or the identification read is presented, so `irq_o` and `iid_o` are due one cycle after that stimulus. The bench samples them just after that edge, and the value of `line_err_i` is still applied when it does. A behavioural integer model advances at the same points and is compared on every cycle. Explicit checks count ticks to the exact expiry boundary, including a 256-tick limit written through the high byte.

// File: rtl/rto_pkg.sv
package rto_pkg;

    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 2 * BYTE_W;
    localparam int ADDR_W   = 3;
    localparam int IID_W    = 4;
    localparam int MODE_BIT = 6;

    typedef enum logic [ADDR_W-1:0] {
        RA_DATA  = 3'd0,
        RA_TLO   = 3'd1,
        RA_THI   = 3'd2,
        RA_IDENT = 3'd3,
        RA_LSTAT = 3'd4,
        RA_MSTAT = 3'd5,
        RA_XCTRL = 3'd6,
        RA_SPARE = 3'd7
    } reg_addr_e;

    typedef enum logic [IID_W-1:0] {
        IID_NONE = 4'b0001,
        IID_LINE = 4'b0110,
        IID_TMO  = 4'b1100
    } iid_e;

    typedef enum logic [2:0] {
        ACT_CLEAR,
        ACT_RELOAD,
        ACT_HOLD,
        ACT_DEC,
        ACT_EXPIRE
    } cnt_act_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        reg_addr_e         addr;
        logic [BYTE_W-1:0] data;
    } bus_req_t;

    typedef struct packed {
        logic [CNT_W-1:0] limit;
        logic             periodic;
    } cfg_t;

    function automatic logic is_passive_rd(reg_addr_e a);
        return (a == RA_DATA) || (a == RA_LSTAT) || (a == RA_MSTAT);
    endfunction

    function automatic logic [BYTE_W-1:0] iid_to_byte(iid_e c);
        return {{(BYTE_W-IID_W){1'b0}}, c};
    endfunction

endpackage

// File: rtl/rto_regs.sv
module rto_regs
    import rto_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req_i,
    input  iid_e              iid_i,
    input  logic              line_err_i,
    output cfg_t              cfg_o,
    output logic              ident_rd_o,
    output logic              status_rd_o,
    output logic [BYTE_W-1:0] rdata_o
);

    logic [BYTE_W-1:0] lo_q, hi_q, xctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q    <= '0;
            hi_q    <= '0;
            xctrl_q <= '0;
        end else if (req_i.wr) begin
            case (req_i.addr)
                RA_TLO:   lo_q    <= req_i.data;
                RA_THI:   hi_q    <= req_i.data;
                RA_XCTRL: xctrl_q <= req_i.data;
                default:  ;
            endcase
        end
    end

    always_comb begin
        cfg_o.limit    = {hi_q, lo_q};
        cfg_o.periodic = xctrl_q[MODE_BIT];
    end

    always_comb begin
        rdata_o = '0;
        if (req_i.rd) begin
            case (req_i.addr)
                RA_TLO:   rdata_o = lo_q;
                RA_THI:   rdata_o = hi_q;
                RA_IDENT: rdata_o = iid_to_byte(iid_i);
                RA_LSTAT: rdata_o = {{(BYTE_W-1){1'b0}}, line_err_i};
                RA_XCTRL: rdata_o = xctrl_q;
                default:  rdata_o = '0;
            endcase
        end
    end

    assign ident_rd_o  = req_i.rd && (req_i.addr == RA_IDENT);
    assign status_rd_o = req_i.rd && is_passive_rd(req_i.addr);

    AST_LO_BYTE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (req_i.wr && req_i.addr == RA_TLO) |=> cfg_o.limit[BYTE_W-1:0] == $past(req_i.data)); // R2

    AST_HI_BYTE_WRITE: assert property (@(posedge clk) disable iff (rst)
        (req_i.wr && req_i.addr == RA_THI) |=> cfg_o.limit[CNT_W-1:BYTE_W] == $past(req_i.data)); // R2

endmodule

// File: rtl/rto_counter.sv
module rto_counter
    import rto_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cfg_t cfg_i,
    input  logic tick_i,
    input  logic rx_push_i,
    input  logic rx_pop_i,
    input  logic fifo_empty_i,
    output logic expire_o
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;
    cnt_act_e         act;
    logic             fifo_restart;

    assign fifo_restart = !cfg_i.periodic && (rx_push_i || rx_pop_i || fifo_empty_i);

    always_comb begin
        if (cfg_i.limit == '0)          act = ACT_CLEAR;
        else if (fifo_restart)          act = ACT_RELOAD;
        else if (cnt_q == '0)           act = ACT_RELOAD;
        else if (!tick_i)               act = ACT_HOLD;
        else if (cnt_q == CNT_ONE)      act = ACT_EXPIRE;
        else                            act = ACT_DEC;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            case (act)
                ACT_CLEAR:  cnt_q <= '0;
                ACT_RELOAD: cnt_q <= cfg_i.limit;
                ACT_EXPIRE: cnt_q <= cfg_i.limit;
                ACT_DEC:    cnt_q <= cnt_q - CNT_ONE;
                default:    cnt_q <= cnt_q;
            endcase
        end
    end

    assign expire_o = (act == ACT_EXPIRE);

    AST_EMPTY_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (!cfg_i.periodic && fifo_empty_i && cfg_i.limit != '0) |=> cnt_q == $past(cfg_i.limit)); // R3

    AST_PERIODIC_COUNTS: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.periodic && tick_i && cnt_q > CNT_ONE && cfg_i.limit != '0)
        |=> cnt_q == $past(cnt_q) - CNT_ONE); // R5

    AST_ZERO_LIMIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cfg_i.limit == '0) |=> cnt_q == '0); // R10

endmodule

// File: rtl/rto_irq.sv
module rto_irq
    import rto_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic expire_i,
    input  logic ident_rd_i,
    input  logic status_rd_i,
    input  logic line_err_i,
    output iid_e iid_o,
    output logic irq_o
);

    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
        end else if (expire_i) begin
            pend_q <= 1'b1;
        end else if (ident_rd_i && !line_err_i) begin
            pend_q <= 1'b0;
        end
    end

    always_comb begin
        if (line_err_i)  iid_o = IID_LINE;
        else if (pend_q) iid_o = IID_TMO;
        else             iid_o = IID_NONE;
    end

    assign irq_o = (iid_o != IID_NONE);

    AST_ID_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ident_rd_i && !line_err_i && !expire_i) |=> !pend_q); // R7

    AST_PASSIVE_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (status_rd_i && !expire_i) |=> $stable(pend_q)); // R8

    AST_SET_NEEDS_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(expire_i)); // R3

    AST_LINE_READ_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (ident_rd_i && line_err_i && pend_q) |=> pend_q); // R9

endmodule

// File: rtl/rto_unit.sv
module rto_unit
    import rto_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              rx_push_i,
    input  logic              rx_pop_i,
    input  logic              fifo_empty_i,
    input  logic              line_err_i,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [BYTE_W-1:0] bus_wdata_i,
    output logic [BYTE_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic [IID_W-1:0]  iid_o
);

    bus_req_t req;
    cfg_t     cfg;
    iid_e     iid_w;
    logic     ident_rd, status_rd, expire;

    always_comb begin
        req.rd   = bus_sel_i && !bus_wr_i;
        req.wr   = bus_sel_i && bus_wr_i;
        req.addr = reg_addr_e'(bus_addr_i);
        req.data = bus_wdata_i;
    end

    rto_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .req_i       (req),
        .iid_i       (iid_w),
        .line_err_i  (line_err_i),
        .cfg_o       (cfg),
        .ident_rd_o  (ident_rd),
        .status_rd_o (status_rd),
        .rdata_o     (bus_rdata_o)
    );

    rto_counter u_cnt (
        .clk          (clk),
        .rst          (rst),
        .cfg_i        (cfg),
        .tick_i       (tick_i),
        .rx_push_i    (rx_push_i),
        .rx_pop_i     (rx_pop_i),
        .fifo_empty_i (fifo_empty_i),
        .expire_o     (expire)
    );

    rto_irq u_irq (
        .clk         (clk),
        .rst         (rst),
        .expire_i    (expire),
        .ident_rd_i  (ident_rd),
        .status_rd_i (status_rd),
        .line_err_i  (line_err_i),
        .iid_o       (iid_w),
        .irq_o       (irq_o)
    );

    assign iid_o = iid_w;

    AST_ZERO_LIMIT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (cfg.limit == '0 && $past(cfg.limit == '0)) |-> !$rose(iid_o == IID_TMO && !line_err_i)); // R10

    AST_IRQ_FOLLOWS_IID: assert property (@(posedge clk) disable iff (rst)
        (line_err_i || $past(expire)) |-> irq_o); // R9

endmodule

// File: tb/rto_unit_test.sv
module rto_unit_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 0, rx_push_i = 0, rx_pop_i = 0, fifo_empty_i = 1, line_err_i = 0;
    logic       bus_sel_i = 0, bus_wr_i = 0;
    logic [2:0] bus_addr_i = 0;
    logic [7:0] bus_wdata_i = 0;
    logic [7:0] bus_rdata_o;
    logic       irq_o;
    logic [3:0] iid_o;

    rto_unit uut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .rx_push_i(rx_push_i), .rx_pop_i(rx_pop_i),
        .fifo_empty_i(fifo_empty_i), .line_err_i(line_err_i), .bus_sel_i(bus_sel_i),
        .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o), .irq_o(irq_o), .iid_o(iid_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_vec = 0, n_bad = 0;
    string cur_req = "R1";
    bit    g_empty = 1, g_lerr = 0;

    // behavioural reference state
    int m_cnt = 0, m_lo = 0, m_hi = 0, m_ctrl = 0;
    bit m_pend = 0;

    task automatic check(string req, string what, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int exp_iid(bit le, bit p);
        if (le) return 6;
        if (p) return 12;
        return 1;
    endfunction

    function automatic int exp_rdata(int a, bit le);
        case (a)
            1: return m_lo;
            2: return m_hi;
            3: return exp_iid(le, m_pend);
            4: return int'(le);
            6: return m_ctrl;
            default: return 0;
        endcase
    endfunction

    task automatic step(bit tk, bit pu, bit po, bit sel, bit wr, int addr, int wd);
        int lim; bit per; bit fire; int n_cnt; bit n_pend;
        @(negedge clk);
        tick_i = tk; rx_push_i = pu; rx_pop_i = po; fifo_empty_i = g_empty; line_err_i = g_lerr;
        bus_sel_i = sel; bus_wr_i = wr; bus_addr_i = 3'(addr); bus_wdata_i = 8'(wd);
        #1;
        if (sel && !wr) check(cur_req, "rdata", int'(bus_rdata_o), exp_rdata(addr, g_lerr));
        lim = m_hi * 256 + m_lo;
        per = m_ctrl[6];
        fire = 0;
        n_cnt = m_cnt;
        if (lim == 0) n_cnt = 0;
        else if (!per && (pu || po || g_empty)) n_cnt = lim;
        else if (m_cnt == 0) n_cnt = lim;
        else if (tk) begin
            if (m_cnt == 1) begin fire = 1; n_cnt = lim; end
            else n_cnt = m_cnt - 1;
        end
        n_pend = m_pend;
        if (fire) n_pend = 1;
        else if (sel && !wr && addr == 3 && !g_lerr) n_pend = 0;
        if (sel && wr) begin
            if (addr == 1) m_lo = wd;
            if (addr == 2) m_hi = wd;
            if (addr == 6) m_ctrl = wd;
        end
        @(posedge clk); #1;
        m_cnt = n_cnt; m_pend = n_pend;
        check(cur_req, "irq_o", int'(irq_o), int'(exp_iid(g_lerr, m_pend) != 1));
        check(cur_req, "iid_o", int'(iid_o), exp_iid(g_lerr, m_pend));
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) step(1, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic wreg(int a, int v); step(0, 0, 0, 1, 1, a, v); endtask
    task automatic rreg(int a);        step(0, 0, 0, 1, 0, a, 0); endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        cur_req = "R1";
        check("R1", "reset irq_o", int'(irq_o), 0);
        check("R1", "reset iid_o", int'(iid_o), 1);
        rreg(1); rreg(2); rreg(6);

        // R10: limit zero, nothing fires even with data pending
        cur_req = "R10";
        g_empty = 0;
        step(1, 1, 0, 0, 0, 0, 0);
        ticks(12);
        check("R10", "irq with zero limit", int'(irq_o), 0);
        g_empty = 1;

        // R2 / R11: program limit 5, readback
        cur_req = "R2";
        wreg(1, 5); wreg(2, 0);
        rreg(1); rreg(2);
        check("R2", "limit low readback model", m_lo, 5);

        // R3: empty FIFO holds counter
        cur_req = "R3";
        ticks(10);
        check("R3", "no irq while empty", int'(irq_o), 0);
        g_empty = 0;
        step(0, 1, 0, 0, 0, 0, 0);
        ticks(4);
        check("R3", "irq before 5th tick", int'(irq_o), 0);
        ticks(1);
        check("R3", "irq at 5th tick", int'(irq_o), 1);
        check("R3", "iid timeout", int'(iid_o), 12);

        // R8: passive reads and writes do not touch the flag
        cur_req = "R8";
        rreg(0); rreg(4); rreg(5); wreg(0, 8'hA5); rreg(7);
        check("R8", "flag kept after status reads", int'(irq_o), 1);

        // R7: identification read clears
        cur_req = "R7";
        rreg(3);
        check("R7", "flag cleared by id read", int'(irq_o), 0);

        // R4: data remains, fires again
        cur_req = "R4";
        ticks(4);
        check("R4", "no refire early", int'(irq_o), 0);
        ticks(1);
        check("R4", "refire after full period", int'(irq_o), 1);
        rreg(3);

        // R3: FIFO read restarts period
        cur_req = "R3";
        ticks(3);
        step(0, 0, 1, 0, 0, 0, 0);
        ticks(4);
        check("R3", "pop restarted period", int'(irq_o), 0);
        ticks(1);
        check("R3", "fire after pop period", int'(irq_o), 1);
        rreg(3);

        // R9: line error priority
        cur_req = "R9";
        ticks(5);
        check("R9", "timeout pending", int'(iid_o), 12);
        g_lerr = 1;
        step(0, 0, 0, 0, 0, 0, 0);
        check("R9", "line error wins", int'(iid_o), 6);
        rreg(3);
        g_lerr = 0;
        step(0, 0, 0, 0, 0, 0, 0);
        check("R9", "timeout kept under line read", int'(iid_o), 12);
        rreg(3);
        check("R9", "cleared when reported", int'(irq_o), 0);
        g_empty = 1;
        step(0, 0, 1, 0, 0, 0, 0);

        // R5: periodic mode runs with empty FIFO and ignores strobes
        cur_req = "R5";
        wreg(6, 8'h40);
        rreg(6);
        ticks(2);
        step(1, 1, 0, 0, 0, 0, 0);
        step(1, 0, 1, 0, 0, 0, 0);
        check("R5", "no fire after 4", int'(irq_o), 0);
        ticks(1);
        check("R5", "periodic fire", int'(irq_o), 1);
        rreg(3);
        ticks(5);
        check("R5", "periodic refire", int'(irq_o), 1);
        rreg(3);

        // R7: expiry in the same cycle as id read keeps flag
        cur_req = "R7";
        ticks(4);
        step(1, 0, 0, 1, 0, 3, 0);
        check("R7", "expiry beats clear", int'(irq_o), 1);
        rreg(3);

        // R6: back to data-pending mode with empty FIFO
        cur_req = "R6";
        wreg(6, 0);
        ticks(12);
        check("R6", "no fire after switch", int'(irq_o), 0);

        // R10 in periodic mode
        cur_req = "R10";
        wreg(6, 8'h40);
        wreg(1, 0);
        ticks(20);
        check("R10", "zero limit periodic quiet", int'(irq_o), 0);

        // R11 / R2: high byte gives 256
        cur_req = "R11";
        wreg(2, 1);
        step(0, 0, 0, 0, 0, 0, 0);
        ticks(255);
        check("R11", "no fire at 255", int'(irq_o), 0);
        ticks(1);
        check("R2", "fire at 256 via high byte", int'(irq_o), 1);
        rreg(3);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule